// File: doc/BRIEF.md
# Four-Source Microsequencer With Interrupt Branch

This block is the next-state engine of a microprogrammed processor controller. Each cycle it loads a 6-bit microstate register from one of four places. The first is the next-state field of the current control word. The other three are small lookup tables: one indexed by the instruction opcode, one indexed by a compare result, and one indexed by a pending-interrupt flag. Two steering bits in the control word choose the source. When both are set, the interrupt table is used, so a microprogram can branch into an interrupt-entry routine at the start of an instruction fetch.

The block also keeps the one-bit interrupt-enable flag. Microcode sets or clears it with a load strobe and a data bit in the control word. This is how enable, disable and return-from-interrupt sequences change it. The pending-interrupt flag is the enable flag ANDed with a shared, possibly undriven interrupt line. That line is resolved to a clean 0 or 1 before use. All three tables are parameters, so each microprogram supplies its own dispatch contents.

Top module: `useq_core`

## Requirements
- R1: While reset is asserted, and after it is released, the microstate reads 0 and the interrupt-enable flag reads 0 until the first clock edge that loads them.
- R2: With control-word bits 23 and 24 both 0, the next microstate equals control-word bits 5:0.
- R3: With bit 23 set and bit 24 clear, the next microstate is the opcode-table entry selected by the 4-bit opcode. Entry i occupies table bits 6i+5:6i.
- R4: With bit 24 set and bit 23 clear, the next microstate is the condition-table entry selected by the compare input. Entry 0 (false) is table bits 5:0 and entry 1 (true) is bits 11:6.
- R5: With bits 23 and 24 both set, the next microstate is the interrupt-table entry selected by the pending flag. Entry 0 (false) is bits 5:0 and entry 1 (true) is bits 11:6.
- R6: The pending flag is 1 only when the enable flag holds 1 and the interrupt line is 1. With the enable flag at 0, an asserted line selects the false entry.
- R7: A clock edge with control-word bit 26 set loads the enable flag from bit 27. With bit 26 clear, the enable flag keeps its value whatever bit 27 is.
- R8: An interrupt line that nothing drives (high impedance or unknown) counts as 0 for the pending flag.
- R9: When a word both selects the interrupt table and loads the enable flag, the table lookup uses the enable value held before that edge.
- R10: Whenever a table is selected, control-word bits 5:0 have no effect on the next microstate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_word | input | 32 | Current control word from the microcode store |
| opcode | input | 4 | Instruction opcode used to index the opcode table |
| cmp_true | input | 1 | Compare result used to index the condition table |
| int_line | input | 1 | Shared interrupt request line, may be undriven |
| state | output | 6 | Current microstate |
| int_en | output | 1 | Current interrupt-enable flag |

## Verification
A wrong source choice or a wrong table slice shows up on `state` one clock after the control word that requested it, because the microstate is a single register fed from the input ports. A corrupted enable flag is visible directly on `int_en` one edge after the word that loads it. It also shows up one edge later as a wrong interrupt-table entry on `state`. The tests use table contents that differ from each other and from the next-state field, so a wrong selection cannot produce the expected value by coincidence.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned CW_W       = 32;
  localparam int unsigned STATE_W    = 6;
  localparam int unsigned OPC_W      = 4;
  localparam int unsigned NS_LSB     = 0;
  localparam int unsigned OPSEL_BIT  = 23;
  localparam int unsigned CNDSEL_BIT = 24;
  localparam int unsigned IELD_BIT   = 26;
  localparam int unsigned IEVAL_BIT  = 27;
  localparam int unsigned OPC_N      = 1 << OPC_W;

  typedef enum logic [1:0] {
    SRC_FIELD = 2'b00,
    SRC_OPC   = 2'b01,
    SRC_COND  = 2'b10,
    SRC_INT   = 2'b11
  } nsrc_e;

  // Default opcode dispatch: entry i points at microstate 16+i.
  function automatic logic [OPC_N*STATE_W-1:0] default_opc_tab();
    logic [OPC_N*STATE_W-1:0] t;
    t = '0;
    for (int i = 0; i < OPC_N; i++) t[i*STATE_W +: STATE_W] = STATE_W'(16 + i);
    return t;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/useq_ie_reg.sv
module useq_ie_reg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic ld_en,
  input  logic ld_val,
  input  logic int_line,
  output logic ie_q,
  output logic pending
);
  logic ie_d;
  logic line_clean;

  // Only a solid 1 counts as a request; z or x resolves to 0.
  always_comb line_clean = (int_line === 1'b1);

  always_comb begin
    ie_d = ie_q;
    if (ld_en) ie_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ie_q <= 1'b0;
    else             ie_q <= ie_d;
  end

  always_comb pending = ie_q & line_clean;

  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_en |=> ie_q == $past(ld_val)); // R7
  AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_en |=> $stable(ie_q)); // R7
  AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ie_q |-> !pending); // R6
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
#(
  parameter logic [OPC_N*STATE_W-1:0] OPC_TABLE  = default_opc_tab(),
  parameter logic [2*STATE_W-1:0]     COND_TABLE = {6'd33, 6'd32},
  parameter logic [2*STATE_W-1:0]     INT_TABLE  = {6'd56, 6'd2}
) (
  input  logic               sel_op,
  input  logic               sel_cnd,
  input  logic [STATE_W-1:0] ns_field,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               cmp_true,
  input  logic               pending,
  output logic [STATE_W-1:0] next_state
);
  logic [STATE_W-1:0] opc_arr  [OPC_N];
  logic [STATE_W-1:0] cond_arr [2];
  logic [STATE_W-1:0] int_arr  [2];
  nsrc_e              src;

  for (genvar i = 0; i < OPC_N; i++) begin : g_opc
    assign opc_arr[i] = OPC_TABLE[i*STATE_W +: STATE_W];
  end
  for (genvar j = 0; j < 2; j++) begin : g_two
    assign cond_arr[j] = COND_TABLE[j*STATE_W +: STATE_W];
    assign int_arr[j]  = INT_TABLE[j*STATE_W +: STATE_W];
  end

  always_comb src = nsrc_e'({sel_cnd, sel_op});

  always_comb begin
    unique case (src)
      SRC_OPC:  next_state = opc_arr[opcode];
      SRC_COND: next_state = cond_arr[cmp_true];
      SRC_INT:  next_state = int_arr[pending];
      default:  next_state = ns_field;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter logic [OPC_N*STATE_W-1:0] OPC_TABLE  = default_opc_tab(),
  parameter logic [2*STATE_W-1:0]     COND_TABLE = {6'd33, 6'd32},
  parameter logic [2*STATE_W-1:0]     INT_TABLE  = {6'd56, 6'd2}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW_W-1:0]    ctrl_word,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               cmp_true,
  input  logic               int_line,
  output logic [STATE_W-1:0] state,
  output logic               int_en
);
  logic               rst_i_n;
  logic               pending;
  logic [STATE_W-1:0] state_d;
  logic [STATE_W-1:0] state_q;
  logic               sel_op;
  logic               sel_cnd;

  always_comb begin
    sel_op  = ctrl_word[OPSEL_BIT];
    sel_cnd = ctrl_word[CNDSEL_BIT];
  end

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  useq_ie_reg u_ie (
    .clk        (clk),
    .rst_sync_n (rst_i_n),
    .ld_en      (ctrl_word[IELD_BIT]),
    .ld_val     (ctrl_word[IEVAL_BIT]),
    .int_line   (int_line),
    .ie_q       (int_en),
    .pending    (pending)
  );

  useq_next_sel #(
    .OPC_TABLE  (OPC_TABLE),
    .COND_TABLE (COND_TABLE),
    .INT_TABLE  (INT_TABLE)
  ) u_sel (
    .sel_op     (sel_op),
    .sel_cnd    (sel_cnd),
    .ns_field   (ctrl_word[NS_LSB +: STATE_W]),
    .opcode     (opcode),
    .cmp_true   (cmp_true),
    .pending    (pending),
    .next_state (state_d)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= '0;
    else          state_q <= state_d;
  end

  assign state = state_q;

  AST_FIELD_PATH: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sel_op && !sel_cnd) |=> state == $past(ctrl_word[NS_LSB +: STATE_W])); // R2
  AST_OPC_PATH: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_op && !sel_cnd) |=> state == OPC_TABLE[$past(opcode)*STATE_W +: STATE_W]); // R3
  AST_COND_PATH: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sel_op && sel_cnd) |=> state == COND_TABLE[$past(cmp_true)*STATE_W +: STATE_W]); // R4
  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_op && sel_cnd && !int_en) |=> state == INT_TABLE[STATE_W-1:0]); // R6
  AST_INT_TAKEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sel_op && sel_cnd && int_en && int_line === 1'b1) |=> state == INT_TABLE[2*STATE_W-1:STATE_W]); // R5
endmodule

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;

  localparam int SW = 6;

  function automatic logic [16*SW-1:0] mk_opc();
    logic [16*SW-1:0] t;
    t = '0;
    for (int i = 0; i < 16; i++) t[i*SW +: SW] = SW'((7 * i + 5) % 64);
    return t;
  endfunction

  localparam logic [16*SW-1:0] T_OPC  = mk_opc();
  localparam logic [2*SW-1:0]  T_COND = {6'd42, 6'd21};
  localparam logic [2*SW-1:0]  T_INT  = {6'd60, 6'd9};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   cw;
  logic [3:0]    opc;
  logic          cmp;
  logic          line_drv;
  logic          line_val;
  wire           line_w;
  logic [SW-1:0] st;
  logic          ie;
  int            total = 0;
  int            bad   = 0;

  assign line_w = line_drv ? line_val : 1'bz;

  always #4 clk = ~clk;

  useq_core #(.OPC_TABLE(T_OPC), .COND_TABLE(T_COND), .INT_TABLE(T_INT)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(cw), .opcode(opc), .cmp_true(cmp),
    .int_line(line_w), .state(st), .int_en(ie)
  );

  function automatic logic [31:0] mkcw(logic [5:0] ns, logic op, logic cn, logic ld, logic en);
    logic [31:0] w;
    w = 32'h0;
    w[5:0] = ns; w[23] = op; w[24] = cn; w[26] = ld; w[27] = en;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, let one edge load, sample 2 ns later.
  task automatic step(logic [31:0] w);
    @(negedge clk);
    cw = w;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cw = mkcw(6'd55, 0, 0, 1, 1); opc = 0; cmp = 0; line_drv = 1; line_val = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 state in reset", st, 0);
    chk("R1 ie in reset", ie, 0);
    @(negedge clk);
    cw = 32'h0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 state after release", st, 0);
    chk("R1 ie after release", ie, 0);
  endtask

  task automatic t_field();
    opc = 4'd3; cmp = 1;
    step(mkcw(6'd17, 0, 0, 0, 0)); chk("R2 field 17", st, 17);
    step(mkcw(6'd63, 0, 0, 0, 1)); chk("R2 field 63", st, 63);
    chk("R7 hold when no load", ie, 0);
    step(mkcw(6'd0, 0, 0, 0, 0));  chk("R2 field 0", st, 0);
  endtask

  task automatic t_opcode();
    for (int i = 0; i < 16; i++) begin
      opc = 4'(i);
      step(mkcw(6'd50, 1, 0, 0, 0));
      chk("R3 R10 opcode table", st, (7 * i + 5) % 64);
    end
  endtask

  task automatic t_cond();
    cmp = 0; step(mkcw(6'd11, 0, 1, 0, 0)); chk("R4 R10 cond false", st, 21);
    cmp = 1; step(mkcw(6'd11, 0, 1, 0, 0)); chk("R4 R10 cond true", st, 42);
  endtask

  task automatic t_ie();
    step(mkcw(6'd1, 0, 0, 1, 1)); chk("R7 load 1", ie, 1);
    step(mkcw(6'd1, 0, 0, 0, 0)); chk("R7 hold 1", ie, 1);
    step(mkcw(6'd1, 0, 0, 1, 0)); chk("R7 load 0", ie, 0);
  endtask

  task automatic t_int();
    line_drv = 1; line_val = 1;
    step(mkcw(6'd30, 1, 1, 0, 0)); chk("R6 masked line", st, 9);
    step(mkcw(6'd30, 0, 0, 1, 1)); chk("R7 enable", ie, 1);
    step(mkcw(6'd30, 1, 1, 0, 0)); chk("R5 taken", st, 60);
    line_val = 0;
    step(mkcw(6'd30, 1, 1, 0, 0)); chk("R5 line low", st, 9);
    line_drv = 0;
    step(mkcw(6'd30, 1, 1, 0, 0)); chk("R8 undriven line", st, 9);
  endtask

  task automatic t_same_edge();
    line_drv = 1; line_val = 1;
    step(mkcw(6'd30, 0, 0, 1, 0)); chk("R7 disable", ie, 0);
    step(mkcw(6'd30, 1, 1, 1, 1));
    chk("R9 old ie used (was 0)", st, 9);
    chk("R9 ie loaded 1", ie, 1);
    step(mkcw(6'd30, 1, 1, 1, 0));
    chk("R9 old ie used (was 1)", st, 60);
    chk("R9 ie loaded 0", ie, 0);
  endtask

  task automatic t_reset_mid();
    step(mkcw(6'd44, 0, 0, 1, 1));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async state clear", st, 0);
    chk("R1 async ie clear", ie, 0);
    cw = 32'h0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_field();
        t_opcode();
        t_cond();
        t_ie();
        t_int();
        t_same_edge();
        t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule